// File: doc/BRIEF.md
# Two-Channel PWM DAC with Fine-Adjust Pulses

The block turns a 14-bit code per channel into a pulse train whose average high time, taken over one conversion period, equals the code in resolution ticks. A 14-bit conversion counter advances once per resolution tick. The tick comes from an enable input and is produced outside the block. The counter splits each 16384-tick conversion period into equal base cycles. Within each base cycle, the upper bits of the code give the number of high ticks. The lower bits give the number of base cycles that carry one extra high tick, placed directly after the regular high time. Those extra-tick cycles are spread evenly over the period: a cycle takes the extra tick when its bit-reversed index is below the low field.

A carrier-select bit per channel chooses between two base-cycle lengths:
- Short carrier: 64-tick base cycles, 256 of them per period. This gives fewer duty steps and more fine-adjust cycles.
- Long carrier: 256-tick base cycles, 64 of them per period.

A code whose duty field is zero lies outside the usable range. In that case the output stays low for the whole period. Software loads the codes through a word-wide register port. A new value takes effect when the counter next wraps to zero, so a waveform is never built from two different codes.

Top module: `pwmdac_top`

## Requirements
- R1: Each channel has one 16-bit register. Address 0 selects channel A and address 1 selects channel B. Bits 15..2 hold the code and bit 1 holds the carrier select (0 = short, 1 = long). Bit 0 always reads 1 and ignores writes. Only whole-word writes exist. Read data is registered and appears one clock after the address.
- R2: After reset every register bit is 1, so each register reads 0xFFFF and `pwm_out` is 0. The first period runs code 0x3FFF on the long carrier, which gives 16383 high ticks per channel.
- R3: On the short carrier the base cycle is 64 ticks and code bits 13..8 give the high ticks per cycle. On the long carrier the base cycle is 256 ticks and code bits 13..6 give the high ticks per cycle. The output is high from tick 0 of a base cycle up to that count.
- R4: The low field is code bits 7..0 on the short carrier and bits 5..0 on the long carrier. Base cycle k gets one extra high tick at position "duty count" when the bit-reverse of k, taken over the index width (8 bits short, 6 bits long), is below the low field. The total number of high ticks per period then equals the code.
- R5: The extra ticks are spread evenly over the period. For example, a long-carrier low field of 32 puts the extra tick in every even base cycle and in no odd one.
- R6: When code bits 1..0 are both 0, the channel runs at 12-bit accuracy: the lowest two positions of the reversed index, which come from the two top counter bits, are left out of the fine-adjust compare.
- R7: The valid code range is 0x0100..0x3FFF on the short carrier and 0x0040..0x3FFF on the long carrier. A code outside that range holds the output low for the entire period.
- R8: A register write becomes active only at the tick where the counter is 0. The period in which the write happens completes with the previous code.
- R9: `pwm_out` is registered. After a clock edge that carries a tick at counter value n, it shows the value for n. When `tick_en` is low, neither the counter nor the output changes.
- R10: The two channels share the counter but nothing else. Each follows its own code and carrier select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Resolution tick enable, one tick per high clock |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select (0 = channel A, 1 = channel B) |
| bus_wdata | input | 16 | Write data word |
| bus_rdata | output | 16 | Registered read data for `bus_addr` |
| pwm_out | output | 2 | PWM outputs, bit 0 = channel A |

## Verification
The hardest situation to reach is a register write that lands partway through a period. It must leave the rest of that period on the old code while the next period runs cleanly on the new one. The fine-adjust placement is hard in the same way, because it only shows across hundreds of base cycles. The stimulus therefore writes both channels' next codes early in every period. It then compares every single tick of each full period against a per-tick model, and also checks the total high count. The code pairs step through both range boundaries of both carriers, the even-spread pattern, and the 12-bit mode.

// File: rtl/pwmdac_pkg.sv
package pwmdac_pkg;
  // Default geometry shared by the block and its sub-modules.
  localparam int DAC_BITS  = 14;   // code width and counter width
  localparam int SHORT_LOG = 6;    // log2 of short base cycle (64 ticks)
  localparam int LONG_LOG  = 8;    // log2 of long base cycle (256 ticks)
  localparam int N_CHAN    = 2;

  typedef enum logic {
    CAR_SHORT = 1'b0,
    CAR_LONG  = 1'b1
  } carrier_e;
endpackage

// File: rtl/pwmdac_timebase.sv
module pwmdac_timebase #(
  parameter int CNT_W = pwmdac_pkg::DAC_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic             period_start
);
  // Free-running conversion counter; wraps naturally at 2**CNT_W.
  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_q + 1'b1;
  end

  // A tick taken while the counter reads zero opens a new period.
  assign period_start = tick_en && (cnt_q == '0);

  // R9: counter is frozen while no tick arrives
  a_r9_count_frozen: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(cnt_q));

  // R8: after the last tick of a period the next one starts at zero
  a_r8_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (tick_en && (&cnt_q)) |=> (cnt_q == '0));
endmodule

// File: rtl/pwmdac_regs.sv
module pwmdac_regs #(
  parameter int NCH    = pwmdac_pkg::N_CHAN,
  parameter int DATA_W = pwmdac_pkg::DAC_BITS,
  parameter int AW     = 1,
  localparam int WORD_W = DATA_W + 2,
  localparam int CFG_W  = DATA_W + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [AW-1:0]             addr,
  input  logic [WORD_W-1:0]         wdata,
  output logic [WORD_W-1:0]         rdata_q,
  output logic [NCH-1:0][CFG_W-1:0] cfg_q
);
  // Stored field per channel: {code, carrier}; the reserved bit has no flop.
  for (genvar g = 0; g < NCH; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                              cfg_q[g] <= '1;
      else if (wr_en && (addr == AW'(g)))   cfg_q[g] <= wdata[WORD_W-1:1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    rdata_q <= '1;
    else if (int'(addr) < NCH)  rdata_q <= {cfg_q[addr], 1'b1};
    else                        rdata_q <= '1;
  end

  // R1: the reserved position always reads back as one
  a_r1_reserved_reads_one: assert property (@(posedge clk) disable iff (rst)
    rdata_q[0]);
endmodule

// File: rtl/pwmdac_split.sv
module pwmdac_split #(
  parameter int DATA_W   = pwmdac_pkg::DAC_BITS,
  parameter int BASE_LOG = pwmdac_pkg::SHORT_LOG,
  localparam int IDX_W   = DATA_W - BASE_LOG
) (
  input  logic [DATA_W-1:0] cnt,
  input  logic [DATA_W-1:0] level,
  output logic              wave,
  output logic              valid
);
  logic [BASE_LOG-1:0] pos, duty;
  logic [IDX_W-1:0]    idx, idx_rev, frac;
  logic                coarse, fine;

  assign pos  = cnt[BASE_LOG-1:0];
  assign idx  = cnt[DATA_W-1:BASE_LOG];
  assign duty = level[DATA_W-1:IDX_W];
  assign frac = level[IDX_W-1:0];

  always_comb begin
    for (int i = 0; i < IDX_W; i++) idx_rev[i] = idx[IDX_W-1-i];
  end

  // 12-bit mode: drop the reversed bits that stem from the top counter bits.
  assign coarse = (level[1:0] == 2'b00);

  always_comb begin
    if (coarse) fine = (idx_rev[IDX_W-1:2] < frac[IDX_W-1:2]);
    else        fine = (idx_rev < frac);
  end

  assign wave  = (pos < duty) || ((pos == duty) && fine);
  assign valid = (duty != '0);
endmodule

// File: rtl/pwmdac_channel.sv
module pwmdac_channel #(
  parameter int DATA_W    = pwmdac_pkg::DAC_BITS,
  parameter int SHORT_LOG = pwmdac_pkg::SHORT_LOG,
  parameter int LONG_LOG  = pwmdac_pkg::LONG_LOG,
  localparam int CFG_W    = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              period_start,
  input  logic [DATA_W-1:0] cnt,
  input  logic [CFG_W-1:0]  cfg_new,
  output logic              pwm_q
);
  import pwmdac_pkg::*;

  logic [CFG_W-1:0] act_q, act_now;
  logic [1:0]       wave, valid;
  carrier_e         car;
  logic             hit;

  // Active copy is refreshed only on the first tick of a period; the
  // bypass lets that very tick already use the new code.
  assign act_now = period_start ? cfg_new : act_q;

  always_ff @(posedge clk) begin
    if (rst)               act_q <= '1;
    else if (period_start) act_q <= cfg_new;
  end

  for (genvar g = 0; g < 2; g++) begin : g_car
    localparam int BL = (g == 0) ? SHORT_LOG : LONG_LOG;
    pwmdac_split #(.DATA_W(DATA_W), .BASE_LOG(BL)) u_split (
      .cnt   (cnt),
      .level (act_now[CFG_W-1:1]),
      .wave  (wave[g]),
      .valid (valid[g])
    );
  end

  assign car = carrier_e'(act_now[0]);
  assign hit = valid[car] && wave[car];

  always_ff @(posedge clk) begin
    if (rst)          pwm_q <= 1'b0;
    else if (tick_en) pwm_q <= hit;
  end

  // R9: output holds when no tick arrives
  a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(pwm_q));

  // R8: the active code is untouched inside a period
  a_r8_code_frozen_mid_period: assert property (@(posedge clk) disable iff (rst)
    !period_start |=> $stable(act_q));

  // R7: an empty duty field keeps the output low
  a_r7_out_of_range_low: assert property (@(posedge clk) disable iff (rst)
    (tick_en && (act_now[CFG_W-1:CFG_W-LONG_LOG] == '0) && act_now[0]) |=> !pwm_q);

  // R3: past the duty plus fine tick, a long-carrier cycle stays low
  a_r3_low_after_duty_long: assert property (@(posedge clk) disable iff (rst)
    (tick_en && act_now[0] &&
     (cnt[LONG_LOG-1:0] > act_now[CFG_W-1:CFG_W-LONG_LOG])) |=> !pwm_q);

  // R3: same for the short carrier
  a_r3_low_after_duty_short: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !act_now[0] &&
     (cnt[SHORT_LOG-1:0] > act_now[CFG_W-1:CFG_W-SHORT_LOG])) |=> !pwm_q);
endmodule

// File: rtl/pwmdac_top.sv
module pwmdac_top #(
  parameter int NCH       = pwmdac_pkg::N_CHAN,
  parameter int DATA_W    = pwmdac_pkg::DAC_BITS,
  parameter int SHORT_LOG = pwmdac_pkg::SHORT_LOG,
  parameter int LONG_LOG  = pwmdac_pkg::LONG_LOG,
  localparam int AW       = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int WORD_W   = DATA_W + 2,
  localparam int CFG_W    = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  logic [DATA_W-1:0]         cnt;
  logic                      period_start;
  logic [NCH-1:0][CFG_W-1:0] cfg;

  pwmdac_timebase #(.CNT_W(DATA_W)) u_timebase (
    .clk          (clk),
    .rst          (rst),
    .tick_en      (tick_en),
    .cnt_q        (cnt),
    .period_start (period_start)
  );

  pwmdac_regs #(.NCH(NCH), .DATA_W(DATA_W), .AW(AW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rdata_q (bus_rdata),
    .cfg_q   (cfg)
  );

  // R10: one independent waveform generator per channel
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pwmdac_channel #(
      .DATA_W(DATA_W), .SHORT_LOG(SHORT_LOG), .LONG_LOG(LONG_LOG)
    ) u_chan (
      .clk          (clk),
      .rst          (rst),
      .tick_en      (tick_en),
      .period_start (period_start),
      .cnt          (cnt),
      .cfg_new      (cfg[c]),
      .pwm_q        (pwm_out[c])
    );
  end
endmodule

// File: tb/pwmdac_top_bench.sv
`timescale 1ns/1ps
module pwmdac_top_bench;
  localparam int PER = 16384;
  localparam int NV  = 7;
  // {word A, word B, expected high ticks A, expected high ticks B}
  localparam logic [63:0] VEC [NV] = '{
    {16'h0107, 16'h0401, 16'd65,    16'd256  },  // long 0x041 / short 0x100 edge
    {16'h00FF, 16'h03FD, 16'd0,     16'd0    },  // both just below range
    {16'h0283, 16'hFFFD, 16'd160,   16'd16383},  // even spread / short top
    {16'h48D3, 16'hA971, 16'd4660,  16'd10844},  // 12-bit mode / short mid
    {16'h0101, 16'h0103, 16'd0,     16'd64   },  // 0x040 short bad, long edge
    {16'h7C05, 16'hC003, 16'd7937,  16'd12288},
    {16'h048E, 16'h048C, 16'd291,   16'd291  }   // reserved bit written 0
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [0:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  pwm_out;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  pwmdac_top u_pwmdac_top (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  // Expected output for counter value n under register word w (R3 R4 R6 R7).
  function automatic logic model_bit(int n, logic [15:0] w);
    int code, bl, iw, pos, idx, duty, low, rev;
    code = int'(w[15:2]);
    bl   = w[1] ? 8 : 6;
    iw   = 14 - bl;
    pos  = n % (1 << bl);
    idx  = n >> bl;
    duty = code >> iw;
    low  = code & ((1 << iw) - 1);
    rev  = 0;
    for (int i = 0; i < iw; i++) rev |= ((idx >> i) & 1) << (iw - 1 - i);
    if (duty == 0) return 1'b0;
    return (pos < duty) || ((pos == duty) && (rev < low));
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic [15:0] cur [2];
    int hi_cnt [2];
    int bad [2];
    int bad_n [2];
    logic [15:0] last_w;
    logic held;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    bus_addr = 1'b0;
    @(negedge clk);
    check("R2 reset read channel A", int'(bus_rdata), 16'hFFFF);
    check("R2 reset pwm_out", int'(pwm_out), 0);
    bus_addr = 1'b1;
    @(negedge clk);
    check("R2 reset read channel B", int'(bus_rdata), 16'hFFFF);
    tick_en = 1'b1;

    for (int p = 0; p <= NV; p++) begin
      cur[0] = (p == 0) ? 16'hFFFF : VEC[p-1][63:48];
      cur[1] = (p == 0) ? 16'hFFFF : VEC[p-1][47:32];
      for (int c = 0; c < 2; c++) begin
        hi_cnt[c] = 0;
        bad[c] = 0;
        bad_n[c] = -1;
      end
      for (int n = 0; n < PER; n++) begin
        @(negedge clk);
        for (int c = 0; c < 2; c++) begin
          hi_cnt[c] += int'(pwm_out[c]);
          if (pwm_out[c] != model_bit(n, cur[c])) begin
            bad[c]++;
            if (bad_n[c] < 0) bad_n[c] = n;
          end
        end
        // R1: reads of the words written at ticks 100 and 101
        if (p < NV && n == 103) check("R1 readback A", int'(bus_rdata), int'(VEC[p][63:48] | 16'h1));
        if (p < NV && n == 104) check("R1 readback B", int'(bus_rdata), int'(VEC[p][47:32] | 16'h1));
        // R8: next codes are written early in this period
        if (p < NV && n == 100) begin
          bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = VEC[p][63:48];
        end else if (p < NV && n == 101) begin
          bus_addr = 1'b1; bus_wdata = VEC[p][47:32];
        end else if (n == 102) begin
          bus_wr = 1'b0; bus_addr = 1'b0;
        end else if (n == 103) begin
          bus_addr = 1'b1;
        end
      end
      for (int c = 0; c < 2; c++) begin
        int exp_cnt;
        exp_cnt = (p == 0) ? 16383 : int'(c == 0 ? VEC[p-1][31:16] : VEC[p-1][15:0]);
        if (exp_cnt == 0)
          check($sformatf("R7 period %0d ch %0d high ticks", p, c), hi_cnt[c], 0);
        else
          check($sformatf("R4 R8 R10 period %0d ch %0d high ticks", p, c), hi_cnt[c], exp_cnt);
        check($sformatf("%s period %0d ch %0d tick mismatches (first at %0d)",
                        (cur[c][3:2] == 2'b00) ? "R3 R5 R6" : "R3 R4 R5",
                        p, c, bad_n[c]), bad[c], 0);
      end
    end

    // R9: freeze the tick mid base cycle; output must hold, then resume.
    last_w = VEC[NV-1][63:48];
    @(negedge clk);                       // counter value 0
    @(negedge clk);                       // counter value 1
    tick_en = 1'b0;
    held = pwm_out[0];
    check("R9 value before freeze", int'(held), int'(model_bit(1, last_w)));
    bad[0] = 0;
    repeat (30) begin
      @(negedge clk);
      if (pwm_out[0] != held) bad[0]++;
    end
    check("R9 output held without tick", bad[0], 0);
    tick_en = 1'b1;
    bad[0] = 0;
    for (int n = 2; n < 300; n++) begin
      @(negedge clk);
      if (pwm_out[0] != model_bit(n, last_w)) bad[0]++;
    end
    check("R9 resume after freeze", bad[0], 0);

    summary();
    $finish;
  end
endmodule